// File: doc/BRIEF.md
# Integer ALU with Operation Decoder

This block is the execute-stage arithmetic unit of a small single-cycle integer core. It is purely combinational. A two-bit operation class from the main instruction decoder and the six-bit function field of a register-format instruction are first turned into a three-bit operation code. That code then steers an arithmetic and logic unit that combines two operands into a result and three condition flags. The operands are 32 bits wide by default.

The main decoder uses class 00 for address arithmetic (loads and stores), which always adds. Class 01 is the branch-compare class, which always subtracts, so that the zero flag shows whether the two registers are equal. Class 10 defers the choice to the function field. Carry and overflow are provided for add and subtract, so that surrounding logic can detect unsigned and signed range errors.

The operation code is also driven out, so the execute stage can see which operation was selected. There is no clock, no reset and no handshake: every output follows its inputs within the same cycle.

Top module: `int_alu_unit`

## Requirements
- R1: With class 10, the function codes map to operation codes as follows:
  - function 100000 selects add (op 010);
  - function 100010 selects subtract (op 110);
  - function 100100 selects AND (op 000);
  - function 100101 selects OR (op 001);
  - function 101010 selects set-less-than (op 111).
- R2: With class 00, the operation is add (op 010), whatever the function field holds.
- R3: With class 01, the operation is subtract (op 110), whatever the function field holds.
- R4: Class 11, and any class 10 function code not listed in R1, select the idle code 011. The idle code gives a zero result, with carry and overflow low.
- R5: AND and OR return the bitwise combination of A and B, with carry and overflow low.
- R6: Add returns A+B modulo 2^WIDTH. Carry equals the unsigned carry out of the sum.
- R7: Subtract returns A-B modulo 2^WIDTH. Carry is high exactly when A >= B as unsigned numbers (no borrow).
- R8: For add and subtract, overflow is high exactly when the true signed result does not fit in WIDTH bits.
- R9: Set-less-than returns 1 when A < B as signed numbers and 0 otherwise, with all upper bits zero. This holds even when A-B overflows. Carry and overflow are low for set-less-than.
- R10: The zero flag is high exactly when every bit of the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class_i | input | 2 | Operation class from the main decoder |
| func_i | input | 6 | Function field of the instruction |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_o | output | 3 | Decoded operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| carry_o | output | 1 | Carry (add) or no-borrow (subtract) |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The block holds no state, so a wrong decode or a wrong adder setting shows at the ports in the same evaluation as the stimulus. A mis-decoded class or function code appears on op_o and usually also in result_o. An inverted-operand or carry-in fault shows up as a wrong difference or a wrong carry. The signed-compare path only separates from a plain sign test when the subtraction overflows, so those operand pairs are driven on purpose. Random operands are also mixed with the listed function codes and with unused ones.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int unsigned CLASS_W = 2;
  localparam int unsigned FUNC_W  = 6;
  localparam int unsigned OPC_W   = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_AND  = 3'b000,
    OPC_OR   = 3'b001,
    OPC_ADD  = 3'b010,
    OPC_IDLE = 3'b011,
    OPC_SUB  = 3'b110,
    OPC_SLT  = 3'b111
  } alu_opc_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_ADDR   = 2'b00,
    CLS_CMP    = 2'b01,
    CLS_FIELD  = 2'b10,
    CLS_UNUSED = 2'b11
  } op_class_e;

  localparam logic [FUNC_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNC_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNC_W-1:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import int_alu_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class_i,
  input  logic [FUNC_W-1:0]  func_i,
  output alu_opc_e           opc_o
);

  alu_opc_e field_opc;

  // Second level: function field, used only by class 10
  always_comb begin
    unique case (func_i)
      FN_ADD:  field_opc = OPC_ADD;
      FN_SUB:  field_opc = OPC_SUB;
      FN_AND:  field_opc = OPC_AND;
      FN_OR:   field_opc = OPC_OR;
      FN_SLT:  field_opc = OPC_SLT;
      default: field_opc = OPC_IDLE;
    endcase
  end

  // First level: class from the main decoder
  always_comb begin
    unique case (op_class_e'(op_class_i))
      CLS_ADDR:  opc_o = OPC_ADD;
      CLS_CMP:   opc_o = OPC_SUB;
      CLS_FIELD: opc_o = field_opc;
      default:   opc_o = OPC_IDLE;
    endcase
  end

  // R2 / R3: the fixed classes ignore the function field
  always_comb begin
    p_addr_is_add_r2: assert (op_class_i != CLS_ADDR || opc_o == OPC_ADD);
    p_cmp_is_sub_r3:  assert (op_class_i != CLS_CMP  || opc_o == OPC_SUB);
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o,
  output logic             lt_o
);

  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide_sum;

  // Subtraction as A + ~B + 1, sharing one carry chain
  always_comb begin
    b_eff    = b_i ^ {WIDTH{sub_i}};
    wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
    sum_o    = wide_sum[WIDTH-1:0];
    cout_o   = wide_sum[WIDTH];
    ovf_o    = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    lt_o     = sum_o[MSB] ^ ovf_o;
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             or_sel_i,
  output logic [WIDTH-1:0] res_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign res_o[g] = or_sel_i ? (a_i[g] | b_i[g]) : (a_i[g] & b_i[g]);
  end

endmodule

// File: rtl/int_alu_unit.sv
module int_alu_unit
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [CLASS_W-1:0] op_class_i,
  input  logic [FUNC_W-1:0]  func_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [OPC_W-1:0]   op_o,
  output logic [WIDTH-1:0]   result_o,
  output logic               zero_o,
  output logic               carry_o,
  output logic               ovf_o
);

  alu_opc_e         opc;
  logic [WIDTH-1:0] as_sum, lg_res;
  logic             as_cout, as_ovf, as_lt;
  logic             is_arith;

  alu_op_decode u_dec (
    .op_class_i (op_class_i),
    .func_i     (func_i),
    .opc_o      (opc)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (opc == OPC_SUB || opc == OPC_SLT),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .ovf_o  (as_ovf),
    .lt_o   (as_lt)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i      (a_i),
    .b_i      (b_i),
    .or_sel_i (opc == OPC_OR),
    .res_o    (lg_res)
  );

  always_comb begin
    op_o     = opc;
    is_arith = (opc == OPC_ADD) || (opc == OPC_SUB);
    unique case (opc)
      OPC_AND, OPC_OR:  result_o = lg_res;
      OPC_ADD, OPC_SUB: result_o = as_sum;
      OPC_SLT:          result_o = {{(WIDTH-1){1'b0}}, as_lt};
      default:          result_o = '0;
    endcase
    carry_o = is_arith & as_cout;
    ovf_o   = is_arith & as_ovf;
    zero_o  = ~|result_o;
  end

  // Cross-checks between decoder, datapath units and flag logic
  always_comb begin
    p_zero_flag_r10:  assert (zero_o == (result_o == '0));
    p_slt_upper_r9:   assert (opc != OPC_SLT || result_o[WIDTH-1:1] == '0);
    p_logic_flags_r5: assert (!(opc == OPC_AND || opc == OPC_OR) || (!carry_o && !ovf_o));
    p_idle_zero_r4:   assert (opc != OPC_IDLE || (result_o == '0 && !carry_o && !ovf_o));
  end

endmodule

// File: tb/test_int_alu_unit.sv
module test_int_alu_unit;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;

  logic          clk = 1'b0;
  logic [1:0]    cls;
  logic [5:0]    fn;
  logic [W-1:0]  a, b;
  logic [2:0]    op;
  logic [W-1:0]  res;
  logic          zero, carry, ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu_unit #(.WIDTH(W)) i_int_alu_unit (
    .op_class_i (cls),
    .func_i     (fn),
    .a_i        (a),
    .b_i        (b),
    .op_o       (op),
    .result_o   (res),
    .zero_o     (zero),
    .carry_o    (carry),
    .ovf_o      (ovf)
  );

  function automatic logic [2:0] exp_op(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 3'b010;
    if (c == 2'b01) return 3'b110;
    if (c == 2'b11) return 3'b011;
    case (f)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b011;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'b000, 3'b001: return "R5";
      3'b010:         return "R6";
      3'b110:         return "R7";
      3'b111:         return "R9";
      default:        return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] c, input logic [5:0] f,
                     input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2:0]   eo;
    logic [W-1:0] er;
    logic         ec, ev;
    longint       sx, sy, st;
    @(negedge clk);
    cls = c; fn = f; a = x; b = y;
    #1;
    eo = exp_op(c, f);
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    ec = 1'b0; ev = 1'b0; er = '0;
    case (eo)
      3'b000: er = x & y;
      3'b001: er = x | y;
      3'b010: begin
        er = x + y;
        ec = (({1'b0, x} + {1'b0, y}) >> W) != 0;
        st = sx + sy;
        ev = (st > 64'sh7fffffff) || (st < -64'sh80000000);
      end
      3'b110: begin
        er = x - y;
        ec = (x >= y);
        st = sx - sy;
        ev = (st > 64'sh7fffffff) || (st < -64'sh80000000);
      end
      3'b111: er = (sx < sy) ? 1 : 0;
      default: er = '0;
    endcase
    chk(op == eo, (c == 2'b00) ? "R2" : (c == 2'b01) ? "R3" : "R1", "op", W'(op), W'(eo));
    chk(res == er, req_of(eo), "result", res, er);
    chk(carry == ec, req_of(eo), "carry", W'(carry), W'(ec));
    chk(ovf == ev, "R8", "overflow", W'(ovf), W'(ev));
    chk(zero == (er == '0), "R10", "zero", W'(zero), W'(er == '0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] fcodes [5];
    fcodes[0] = 6'b100000; fcodes[1] = 6'b100010; fcodes[2] = 6'b100100;
    fcodes[3] = 6'b100101; fcodes[4] = 6'b101010;
    void'($urandom(32'd20240611));
    cls = 2'b11; fn = '0; a = '0; b = '0;
    // R4: idle state with class 11
    run(2'b11, 6'b100000, 32'hdeadbeef, 32'h12345678);
    // R1: each listed function code
    for (int i = 0; i < 5; i++) run(2'b10, fcodes[i], 32'hf0f0a5a5, 32'h0ff05a5a);
    // R2 / R3: class ignores function field
    run(2'b00, 6'b100100, 32'h00000010, 32'hfffffff0);
    run(2'b01, 6'b100101, 32'h00001234, 32'h00001234);
    // R4: unmapped function code
    run(2'b10, 6'b000000, 32'hffffffff, 32'hffffffff);
    // R6 / R8: carry wrap and signed overflow on add
    run(2'b10, 6'b100000, 32'hffffffff, 32'h00000001);
    run(2'b10, 6'b100000, 32'h7fffffff, 32'h00000001);
    run(2'b10, 6'b100000, 32'h80000000, 32'h80000000);
    // R7 / R8: borrow and overflow on subtract
    run(2'b10, 6'b100010, 32'h00000000, 32'h00000001);
    run(2'b10, 6'b100010, 32'h80000000, 32'h00000001);
    run(2'b10, 6'b100010, 32'h7fffffff, 32'hffffffff);
    // R9: signed compare across overflow
    run(2'b10, 6'b101010, 32'h80000000, 32'h00000001);
    run(2'b10, 6'b101010, 32'h00000001, 32'h80000000);
    run(2'b10, 6'b101010, 32'h7fffffff, 32'h80000000);
    run(2'b10, 6'b101010, 32'h00000005, 32'h00000005);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] c;
      logic [5:0] f;
      logic [W-1:0] x, y;
      c = 2'($urandom_range(0, 3));
      f = ($urandom_range(0, 3) != 0) ? fcodes[$urandom_range(0, 4)] : 6'($urandom);
      x = $urandom;
      y = ($urandom_range(0, 7) == 0) ? x : $urandom;
      if ($urandom_range(0, 5) == 0) x[W-1] = ~y[W-1];
      run(c, f, x, y);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule